// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Zero Detect

This block is the combinational compute stage of a small 8-bit accumulator machine. It takes the accumulator value, the general register value and an immediate byte, and a 4-bit operation code that the CPU takes unchanged from the low nibble of the instruction opcode. The unit returns the 8-bit result and a zero indication. It also returns an update hint that tells the CPU whether its zero flag register should capture that indication.

Codes 8 to F select add, subtract, increment, immediate load, AND, OR, XOR and complement. Each of these asserts the update hint. Codes 0 to 7 belong to moves, memory accesses, jumps and the no-op. For these codes the unit passes the accumulator through and leaves the hint low, so the flag keeps its value. There is no clock, no storage and no handshake. The result settles within one combinational path, and the surrounding CPU registers it.

Top module: `acc_alu`

## Requirements
- R1: Code 4'b1000 gives acc + reg modulo 256. There is no carry output.
- R2: Code 4'b1001 gives acc - reg modulo 256, so 0x00 - 0x01 = 0xFF.
- R3: Code 4'b1010 gives acc + 1 modulo 256, so 0xFF becomes 0x00.
- R4: Code 4'b1011 gives the immediate byte unchanged, whatever acc and reg hold.
- R5: Codes 4'b1100, 4'b1101 and 4'b1110 give bitwise AND, OR and XOR of acc and reg.
- R6: Code 4'b1111 gives the bitwise complement of acc. The reg input has no effect on it.
- R7: The zero output is 1 exactly when all 8 result bits are 0.
- R8: The flag update hint is 1 for codes 8 to F and 0 for codes 0 to 7.
- R9: For codes 0 to 7 the result equals acc. The reg and immediate inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| reg_i | input | 8 | General register operand |
| imm_i | input | 8 | Immediate byte from the instruction stream |
| sel_i | input | 4 | Operation code, the low opcode nibble |
| result_o | output | 8 | Operation result |
| zero_o | output | 1 | 1 when the result is all zeros |
| flag_we_o | output | 1 | 1 when the zero flag should be updated |

## Verification
The block holds no state. A fault in it therefore shows in the same evaluation as the stimulus that triggers it: a wrong result byte, or a zero bit that disagrees with that byte. The boundary cases that expose a wrong carry or borrow are wrap-around at 0xFF and 0x00, and a subtract that gives exactly zero. A mis-decoded code shows up as two failures together: a result taken from the wrong sub-unit, and a raised or dropped update hint. This matters most for codes 0 to 7, where the flag must stay untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 4'h8,
    OP_SUB  = 4'h9,
    OP_INC  = 4'hA,
    OP_IMM  = 4'hB,
    OP_AND  = 4'hC,
    OP_OR   = 4'hD,
    OP_XOR  = 4'hE,
    OP_NOT  = 4'hF
  } alu_op_e;

  // Sub-unit kinds taken from the two low code bits
  typedef enum logic [1:0] {
    AK_ADD = 2'b00,
    AK_SUB = 2'b01,
    AK_INC = 2'b10,
    AK_NA  = 2'b11
  } arith_kind_e;

  typedef enum logic [1:0] {
    LK_AND = 2'b00,
    LK_OR  = 2'b01,
    LK_XOR = 2'b10,
    LK_NOT = 2'b11
  } logic_kind_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   kind_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] addend;
  logic         cin;

  // One shared adder: subtract uses inverted operand plus one
  always_comb begin
    unique case (arith_kind_e'(kind_i))
      AK_SUB:  begin addend = ~b_i;        cin = 1'b1; end
      AK_INC:  begin addend = '0;          cin = 1'b1; end
      default: begin addend = b_i;         cin = 1'b0; end
    endcase
  end

  assign sum_o = a_i + addend + {{(W-1){1'b0}}, cin};

  // R2: a difference added back to the subtrahend restores the minuend
  always_comb begin
    if (kind_i == AK_SUB)
      p_sub_inverse_r2: assert (W'(sum_o + b_i) == a_i)
        else $error("subtract result not inverse of add");
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   kind_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (logic_kind_e'(kind_i))
        LK_AND:  y_o[i] = a_i[i] & b_i[i];
        LK_OR:   y_o[i] = a_i[i] | b_i[i];
        LK_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        default: y_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_zero.sv
module acc_alu_zero #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int S = SEL_W
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] imm_i,
  input  logic [S-1:0] sel_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         flag_we_o
);
  localparam int TOP = S - 1;

  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         is_alu;

  assign is_alu = sel_i[TOP];

  acc_alu_arith #(.W(W)) u_arith (
    .a_i   (acc_i),
    .b_i   (reg_i),
    .kind_i(sel_i[1:0]),
    .sum_o (arith_y)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a_i   (acc_i),
    .b_i   (reg_i),
    .kind_i(sel_i[1:0]),
    .y_o   (logic_y)
  );

  always_comb begin
    if (!is_alu)
      result_o = acc_i;
    else if (sel_i[2])
      result_o = logic_y;
    else if (sel_i[1:0] == 2'b11)
      result_o = imm_i;
    else
      result_o = arith_y;
  end

  acc_alu_zero #(.W(W)) u_zero (
    .val_i (result_o),
    .zero_o(zero_o)
  );

  assign flag_we_o = is_alu;

  // R7: the zero indication agrees with the selected result byte
  always_comb begin
    p_zero_match_r7: assert (zero_o == (result_o == '0))
      else $error("zero output disagrees with result");
  end

  // R9: non-arithmetic codes leave the accumulator untouched
  always_comb begin
    if (!sel_i[TOP])
      p_pass_acc_r9: assert (result_o == acc_i && !flag_we_o)
        else $error("low code altered accumulator or raised hint");
  end

  // R4: immediate load returns the immediate byte
  always_comb begin
    if (sel_i == OP_IMM)
      p_imm_pass_r4: assert (result_o == imm_i)
        else $error("immediate not passed through");
  end
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic [7:0] acc, rg, imm;
  logic [3:0] sel;
  logic [7:0] res;
  logic       zf, we;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  acc_alu u0 (
    .acc_i(acc), .reg_i(rg), .imm_i(imm), .sel_i(sel),
    .result_o(res), .zero_o(zf), .flag_we_o(we)
  );

  task automatic apply(input logic [3:0] s, input logic [7:0] a,
                       input logic [7:0] r, input logic [7:0] i);
    @(posedge clk);
    sel = s; acc = a; rg = r; imm = i;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] er,
                     input bit ez, input bit ew);
    n_chk++;
    if (res !== er || zf !== ez || we !== ew) begin
      n_fail++;
      $display("FAIL %s sel=%h: got res=%h z=%b we=%b, exp res=%h z=%b we=%b",
               tag, sel, res, zf, we, er, ez, ew);
    end
  endtask

  task automatic t_reset_state();
    apply(4'h0, 8'h00, 8'h00, 8'h00);
    chk("R9 idle", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_add();
    apply(4'h8, 8'h12, 8'h34, 8'h00); chk("R1 add", 8'h46, 1'b0, 1'b1);
    apply(4'h8, 8'hFF, 8'h01, 8'h00); chk("R1 wrap", 8'h00, 1'b1, 1'b1);
    apply(4'h8, 8'hC8, 8'h64, 8'h00); chk("R1 wrap2", 8'h2C, 1'b0, 1'b1);
  endtask

  task automatic t_sub();
    apply(4'h9, 8'h50, 8'h20, 8'h00); chk("R2 sub", 8'h30, 1'b0, 1'b1);
    apply(4'h9, 8'h00, 8'h01, 8'h00); chk("R2 borrow", 8'hFF, 1'b0, 1'b1);
    apply(4'h9, 8'h7A, 8'h7A, 8'h00); chk("R2 R7 zero", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_inc();
    apply(4'hA, 8'h41, 8'hEE, 8'h00); chk("R3 inc", 8'h42, 1'b0, 1'b1);
    apply(4'hA, 8'hFF, 8'h00, 8'h00); chk("R3 wrap", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_imm();
    apply(4'hB, 8'hAA, 8'h55, 8'h3C); chk("R4 imm", 8'h3C, 1'b0, 1'b1);
    apply(4'hB, 8'hAA, 8'h55, 8'h00); chk("R4 R7 imm zero", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_logic();
    apply(4'hC, 8'hF0, 8'h3C, 8'h00); chk("R5 and", 8'h30, 1'b0, 1'b1);
    apply(4'hC, 8'hF0, 8'h0F, 8'h00); chk("R5 and zero", 8'h00, 1'b1, 1'b1);
    apply(4'hD, 8'hF0, 8'h0C, 8'h00); chk("R5 or", 8'hFC, 1'b0, 1'b1);
    apply(4'hE, 8'hF0, 8'h3C, 8'h00); chk("R5 xor", 8'hCC, 1'b0, 1'b1);
    apply(4'hE, 8'h99, 8'h99, 8'h00); chk("R5 xor zero", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_not();
    apply(4'hF, 8'h0F, 8'h12, 8'h00); chk("R6 not", 8'hF0, 1'b0, 1'b1);
    apply(4'hF, 8'hFF, 8'hA5, 8'h77); chk("R6 not zero", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_low_codes();
    for (int s = 0; s < 8; s++) begin
      apply(4'(s), 8'h5A, 8'hFF, 8'hC3);
      chk("R8 R9 low code", 8'h5A, 1'b0, 1'b0);
    end
    apply(4'h3, 8'h00, 8'h11, 8'h22);
    chk("R9 R7 low zero", 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a, b;
      a = 8'(k * 37 + 5);
      b = 8'(k * 91 + 200);
      apply(4'h8, a, b, 8'h00);
      chk("R1 sweep", 8'((int'(a) + int'(b)) % 256),
          ((int'(a) + int'(b)) % 256) == 0, 1'b1);
      apply(4'h9, a, b, 8'h00);
      chk("R2 sweep", 8'((int'(a) - int'(b) + 256) % 256),
          a == b, 1'b1);
    end
  endtask

  initial begin
    sel = '0; acc = '0; rg = '0; imm = '0;
    t_reset_state();
    t_add();
    t_sub();
    t_inc();
    t_imm();
    t_logic();
    t_not();
    t_low_codes();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running, exp finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule